// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block runs one complete I2C master message, either a read or a write, on a byte-level bus controller. It does this without a processor in the loop. The controller reports every bus event as a one-cycle event strobe with an 8-bit status code. The sequencer answers each event one clock later with a single command word: generate START, load a byte to shift out, continue receiving, generate STOP, or reset the controller. The command word also carries the acknowledge-enable bit the controller should use for the next received byte.

A message begins with a start pulse. The pulse carries a target address, a direction, a ten-bit-address flag and a byte count. The sequencer encodes the address, and this takes two bytes in ten-bit mode. For a write, payload bytes are pulled from a valid/ready byte stream. For a read, received bytes are delivered on a valid strobe. The last read byte is NACKed. Every message ends with STOP and a one-cycle done pulse that carries a result code. An abort input shortens a message that is already running.

Top module: `i2cseq_top`

## Requirements
- R1: In 7-bit mode, the byte loaded on status 0x08 or 0x10 is `{tgt_addr[6:0], dir}`, where dir is 1 for a read.
- R2: In ten-bit mode, the byte loaded on 0x08/0x10 is `0xF0 | tgt_addr[9:8]<<1 | dir`. The next event, 0x18 for a write or 0x40 for a read, loads `tgt_addr[7:0]`.
- R3: After reset no command, done, read strobe or write-ready is active. A start pulse while idle produces `cmd_start` with `cmd_ack`=1 on the next cycle. A start pulse while a message runs produces no command.
- R4: On a write acknowledgement (0x18 in 7-bit mode, 0xD0 or 0x28), the sequencer does one of two things. If bytes remain, it raises `wr_ready` and waits until `wr_valid`, then loads `wr_data` one cycle later. If no bytes remain, it issues STOP.
- R5: On 0x50 the byte on `ctl_rdata` is delivered on `rd_valid`/`rd_data` and receiving continues. On 0x58 the final byte is delivered, together with STOP and done.
- R6: Each receive command carries `cmd_ack`=0 once exactly one byte remains to be received, and 1 before that.
- R7: A read with byte count 0 issues STOP with done and result 0 right after the address acknowledgement (0x40 or 0xE0), and delivers no byte.
- R8: Status 0x20, 0x30 or 0x48 issues STOP and done with result 1 (no device).
- R9: Any status that is not expected by the sequencer issues STOP together with `cmd_reset`, and done with result 2 (I/O error).
- R10: An abort ends a write at the next write acknowledgement, with STOP, done and result 0, but only once at least one payload byte has been loaded. An abort asserted in the same cycle as that acknowledgement counts.
- R11: An abort during a read forces `cmd_ack`=0 on the next receive command.
- R12: An event while idle produces STOP only, with no done.
- R13: Result codes are 0 for success, 1 for no device and 2 for I/O error. `done` is a one-cycle pulse that always coincides with `cmd_stop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a message (sampled while idle) |
| tgt_addr | input | 10 | Target address (low 7 bits used in 7-bit mode) |
| rd_mode | input | 1 | 1 = read message, 0 = write message |
| ten_mode | input | 1 | 1 = ten-bit addressing |
| byte_cnt | input | CNT_W | Number of payload bytes |
| abort | input | 1 | Request early end of the running message |
| ctl_evt | input | 1 | Controller event strobe |
| ctl_status | input | 8 | Controller status code for the event |
| ctl_rdata | input | 8 | Byte received by the controller |
| cmd_valid | output | 1 | Command word valid (one cycle) |
| cmd_start | output | 1 | Command: generate START |
| cmd_stop | output | 1 | Command: generate STOP |
| cmd_reset | output | 1 | Command: reset the controller |
| cmd_load | output | 1 | Command: shift out `cmd_data` |
| cmd_data | output | 8 | Byte to shift out |
| cmd_ack | output | 1 | Acknowledge-enable for the next received byte |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Write payload byte available |
| wr_ready | output | 1 | Sequencer accepts a payload byte this cycle |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Received byte strobe |
| done | output | 1 | Message finished (one cycle) |
| result | output | 2 | Result code, valid with `done` |

## Verification
An abort request and a write acknowledgement can arrive in the same clock. The same collision can happen between an abort and a read-data event. The bench raises `abort` in the very cycle of the 0x28 strobe after one byte has gone out, and expects STOP, done and result 0 instead of a fresh `wr_ready`. A separate run raises abort one cycle before the first write acknowledgement, and there the first payload byte must still be loaded. During a read, abort is raised just before a 0x50 event. That event must then still deliver its byte, but the receive command must drop `cmd_ack`.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  typedef enum logic [3:0] {
    EV_START,
    EV_ADR_W,
    EV_ADR_R,
    EV_ADR2_W,
    EV_ADR2_R,
    EV_WR_ACK,
    EV_RD_ACK,
    EV_RD_NACK,
    EV_NODEV,
    EV_OTHER
  } ev_cls_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BUSY,
    ST_FEED
  } seq_st_t;

  localparam logic [1:0] RES_OK    = 2'd0;
  localparam logic [1:0] RES_NODEV = 2'd1;
  localparam logic [1:0] RES_IOERR = 2'd2;

  typedef struct packed {
    logic       vld;
    logic       start;
    logic       stop;
    logic       rst;
    logic       load;
    logic [7:0] dat;
    logic       ack;
  } cmd_t;

endpackage

// File: rtl/i2cseq_status_dec.sv
module i2cseq_status_dec
  import i2cseq_pkg::*;
(
  input  logic [7:0] code,
  output ev_cls_t    cls
);

  always_comb begin
    unique case (code)
      8'h08, 8'h10:        cls = EV_START;
      8'h18:               cls = EV_ADR_W;
      8'h40:               cls = EV_ADR_R;
      8'hD0:               cls = EV_ADR2_W;
      8'hE0:               cls = EV_ADR2_R;
      8'h28:               cls = EV_WR_ACK;
      8'h50:               cls = EV_RD_ACK;
      8'h58:               cls = EV_RD_NACK;
      8'h20, 8'h30, 8'h48: cls = EV_NODEV;
      default:             cls = EV_OTHER;
    endcase
  end

endmodule

// File: rtl/i2cseq_addr_enc.sv
module i2cseq_addr_enc #(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ten,
  input  logic              rd,
  output logic [7:0]        first,
  output logic [7:0]        second
);

  localparam int SHORT_W = 7;

  // ten-bit header: fixed 11110 prefix, two high address bits, direction
  always_comb begin
    if (ten) first = {5'b11110, addr[9:8], rd};
    else     first = {addr[SHORT_W-1:0], rd};
    second = addr[7:0];
  end

endmodule

// File: rtl/i2cseq_bytecnt.sv
module i2cseq_bytecnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             is_zero,
  output logic             is_one,
  output logic             is_two,
  output logic             moved
);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             moved_q, moved_n;

  always_comb begin
    cnt_n   = cnt_q;
    moved_n = moved_q;
    if (load) begin
      cnt_n   = load_val;
      moved_n = 1'b0;
    end else if (dec) begin
      cnt_n   = cnt_q - CNT_W'(1);
      moved_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      moved_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      moved_q <= moved_n;
    end
  end

  assign cnt     = cnt_q;
  assign is_zero = (cnt_q == '0);
  assign is_one  = (cnt_q == CNT_W'(1));
  assign is_two  = (cnt_q == CNT_W'(2));
  assign moved   = moved_q;

  // R4: a payload byte is never taken when the count is exhausted
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !is_zero);

endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top
  import i2cseq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [9:0]       tgt_addr,
  input  logic             rd_mode,
  input  logic             ten_mode,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic             abort,
  input  logic             ctl_evt,
  input  logic [7:0]       ctl_status,
  input  logic [7:0]       ctl_rdata,
  output logic             cmd_valid,
  output logic             cmd_start,
  output logic             cmd_stop,
  output logic             cmd_reset,
  output logic             cmd_load,
  output logic [7:0]       cmd_data,
  output logic             cmd_ack,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic [1:0]       result
);

  localparam int ADDR_W = 10;

  seq_st_t          st_q, st_n;
  logic [ADDR_W-1:0] addr_q;
  logic             rd_q, ten_q, abort_q, abort_n, ack_q, ack_n;
  logic             ld_regs;
  cmd_t             cmd_q, cmd_n;
  logic             done_q, done_n;
  logic [1:0]       res_q, res_n;
  logic             rdv_q, rdv_n;
  logic [7:0]       rdd_q, rdd_n;

  ev_cls_t          cls;
  logic [7:0]       adr_first, adr_second;
  logic             cnt_ld, cnt_dec;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero, cnt_one, cnt_two, cnt_moved;
  logic             abort_eff;

  i2cseq_status_dec u_dec (
    .code (ctl_status),
    .cls  (cls)
  );

  i2cseq_addr_enc #(.ADDR_W(ADDR_W)) u_enc (
    .addr   (addr_q),
    .ten    (ten_q),
    .rd     (rd_q),
    .first  (adr_first),
    .second (adr_second)
  );

  i2cseq_bytecnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_ld),
    .load_val (byte_cnt),
    .dec      (cnt_dec),
    .cnt      (cnt),
    .is_zero  (cnt_zero),
    .is_one   (cnt_one),
    .is_two   (cnt_two),
    .moved    (cnt_moved)
  );

  assign abort_eff = abort_q | abort;

  // next-state and command selection
  always_comb begin
    st_n     = st_q;
    cmd_n    = '0;
    cmd_n.ack = ack_q;
    done_n   = 1'b0;
    res_n    = RES_OK;
    rdv_n    = 1'b0;
    rdd_n    = rdd_q;
    ld_regs  = 1'b0;
    cnt_ld   = 1'b0;
    cnt_dec  = 1'b0;
    ack_n    = ack_q;
    wr_ready = 1'b0;
    abort_n  = abort_q | (abort & (st_q != ST_IDLE));

    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_n        = ST_BUSY;
          ld_regs     = 1'b1;
          cnt_ld      = 1'b1;
          ack_n       = 1'b1;
          abort_n     = 1'b0;
          cmd_n.vld   = 1'b1;
          cmd_n.start = 1'b1;
          cmd_n.ack   = 1'b1;
        end else if (ctl_evt) begin
          cmd_n.vld  = 1'b1;
          cmd_n.stop = 1'b1;
        end
      end

      ST_FEED: begin
        wr_ready = 1'b1;
        if (wr_valid) begin
          cmd_n.vld  = 1'b1;
          cmd_n.load = 1'b1;
          cmd_n.dat  = wr_data;
          cnt_dec    = 1'b1;
          st_n       = ST_BUSY;
        end
      end

      ST_BUSY: begin
        if (ctl_evt) begin
          cmd_n.vld = 1'b1;
          unique case (cls)
            EV_START: begin
              cmd_n.load = 1'b1;
              cmd_n.dat  = adr_first;
            end
            EV_ADR_W, EV_ADR2_W, EV_WR_ACK: begin
              if (ten_q && cls == EV_ADR_W) begin
                cmd_n.load = 1'b1;
                cmd_n.dat  = adr_second;
              end else if (cnt_zero || (abort_eff && cnt_moved)) begin
                cmd_n.stop = 1'b1;
                done_n     = 1'b1;
                res_n      = RES_OK;
                st_n       = ST_IDLE;
              end else begin
                cmd_n.vld = 1'b0;
                st_n      = ST_FEED;
              end
            end
            EV_ADR_R, EV_ADR2_R: begin
              if (ten_q && cls == EV_ADR_R) begin
                cmd_n.load = 1'b1;
                cmd_n.dat  = adr_second;
              end else if (cnt_zero) begin
                cmd_n.stop = 1'b1;
                done_n     = 1'b1;
                res_n      = RES_OK;
                st_n       = ST_IDLE;
              end else begin
                if (cnt_one || abort_eff) ack_n = 1'b0;
                cmd_n.ack = ack_n;
              end
            end
            EV_RD_ACK: begin
              rdv_n   = 1'b1;
              rdd_n   = ctl_rdata;
              cnt_dec = 1'b1;
              if (cnt_two || abort_eff) ack_n = 1'b0;
              cmd_n.ack = ack_n;
            end
            EV_RD_NACK: begin
              rdv_n      = 1'b1;
              rdd_n      = ctl_rdata;
              cmd_n.stop = 1'b1;
              done_n     = 1'b1;
              res_n      = RES_OK;
              st_n       = ST_IDLE;
            end
            EV_NODEV: begin
              cmd_n.stop = 1'b1;
              done_n     = 1'b1;
              res_n      = RES_NODEV;
              st_n       = ST_IDLE;
            end
            default: begin
              cmd_n.stop = 1'b1;
              cmd_n.rst  = 1'b1;
              done_n     = 1'b1;
              res_n      = RES_IOERR;
              st_n       = ST_IDLE;
            end
          endcase
        end
      end

      default: st_n = ST_IDLE;
    endcase
  end

  // state and output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      rd_q    <= 1'b0;
      ten_q   <= 1'b0;
      abort_q <= 1'b0;
      ack_q   <= 1'b1;
      cmd_q   <= '0;
      done_q  <= 1'b0;
      res_q   <= RES_OK;
      rdv_q   <= 1'b0;
      rdd_q   <= '0;
    end else begin
      st_q    <= st_n;
      abort_q <= abort_n;
      ack_q   <= ack_n;
      cmd_q   <= cmd_n;
      done_q  <= done_n;
      res_q   <= res_n;
      rdv_q   <= rdv_n;
      rdd_q   <= rdd_n;
      if (ld_regs) begin
        addr_q <= tgt_addr;
        rd_q   <= rd_mode;
        ten_q  <= ten_mode;
      end
    end
  end

  assign cmd_valid = cmd_q.vld;
  assign cmd_start = cmd_q.start;
  assign cmd_stop  = cmd_q.stop;
  assign cmd_reset = cmd_q.rst;
  assign cmd_load  = cmd_q.load;
  assign cmd_data  = cmd_q.dat;
  assign cmd_ack   = cmd_q.ack;
  assign done      = done_q;
  assign result    = res_q;
  assign rd_valid  = rdv_q;
  assign rd_data   = rdd_q;

  // R3: an idle start always yields a START command next cycle
  a_r3_start_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start) |=> (cmd_valid && cmd_start && cmd_ack));

  // R13: completion is always accompanied by STOP
  a_r13_done_with_stop: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_valid && cmd_stop));

  // R9: a controller reset only appears on an I/O-error completion
  a_r9_reset_is_ioerr: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |-> (done && result == RES_IOERR));

  // R12: an idle event yields STOP and no completion
  a_r12_idle_evt: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !start && ctl_evt) |=> (cmd_stop && !done));

  // R4: an accepted payload byte is loaded in the next cycle
  a_r4_feed_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && wr_valid) |=> (cmd_load && !cmd_stop && $past(wr_data) == cmd_data));

  // R5: a delivered byte always goes with a command, never START
  a_r5_rd_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (cmd_valid && !cmd_start && !cmd_load));

endmodule

// File: tb/i2cseq_top_tb.sv
module i2cseq_top_tb_top;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start, rd_mode, ten_mode, abort, ctl_evt, wr_valid;
  logic [9:0]       tgt_addr;
  logic [CNT_W-1:0] byte_cnt;
  logic [7:0]       ctl_status, ctl_rdata, wr_data;
  logic             cmd_valid, cmd_start, cmd_stop, cmd_reset, cmd_load, cmd_ack;
  logic [7:0]       cmd_data, rd_data;
  logic             wr_ready, rd_valid, done;
  logic [1:0]       result;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  i2cseq_top #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_addr(tgt_addr),
    .rd_mode(rd_mode), .ten_mode(ten_mode), .byte_cnt(byte_cnt),
    .abort(abort), .ctl_evt(ctl_evt), .ctl_status(ctl_status),
    .ctl_rdata(ctl_rdata), .cmd_valid(cmd_valid), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .cmd_reset(cmd_reset), .cmd_load(cmd_load),
    .cmd_data(cmd_data), .cmd_ack(cmd_ack), .wr_data(wr_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data),
    .rd_valid(rd_valid), .done(done), .result(result)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic go(input logic [9:0] a, input logic rd, input logic ten,
                    input int n);
    start = 1'b1; tgt_addr = a; rd_mode = rd; ten_mode = ten;
    byte_cnt = CNT_W'(n);
    @(negedge clk);
    start = 1'b0;
    chk("R3 start cmd", {cmd_valid, cmd_start, cmd_ack}, 3'b111);
  endtask

  task automatic ev(input logic [7:0] s, input logic ab);
    ctl_evt = 1'b1; ctl_status = s; abort = ab;
    @(negedge clk);
    ctl_evt = 1'b0; abort = 1'b0;
  endtask

  task automatic expect_end(input string tag, input int res, input int rst);
    chk(tag, {done, cmd_stop, cmd_reset, 2'(result)}, {1'b1, 1'b1, 1'(rst), 2'(res)});
  endtask

  function automatic int wbyte(int a, int i);
    return (a * 7 + i * 29 + 3) % 256;
  endfunction

  // write message of n bytes with 7-bit address a; abort_at: ack index with abort (-1 none)
  task automatic run_write(input int a, input int n, input int abort_at);
    int sent;
    go(10'(a), 1'b0, 1'b0, n);
    ev(8'h08, 1'b0);
    chk("R1 write addr byte", {cmd_load, cmd_data}, {1'b1, 8'(((a % 128) * 2) % 256)});
    sent = 0;
    for (int k = 0; k <= n; k++) begin
      logic ab;
      ab = (k == abort_at);
      wr_data = 8'(wbyte(a, sent));
      ev(k == 0 ? 8'h18 : 8'h28, ab);
      if (sent == n || (ab && sent > 0)) begin
        expect_end(ab ? "R10 abort stop" : "R4 write stop", 0, 0);
        chk("R4 no ready after stop", wr_ready, 0);
        break;
      end
      chk("R4 ready raised", {wr_ready, cmd_valid}, 2'b10);
      @(negedge clk);
      chk("R4 byte loaded", {cmd_load, cmd_data}, {1'b1, 8'(wbyte(a, sent))});
      sent++;
    end
  endtask

  // read message of n bytes; abort_before: index of 0x50 event preceded by abort (-1 none)
  task automatic run_read(input int a, input int n, input int abort_before);
    int left;
    logic ab_seen;
    go(10'(a), 1'b1, 1'b0, n);
    ev(8'h08, 1'b0);
    chk("R1 read addr byte", cmd_data, ((a % 128) * 2 + 1) % 256);
    ev(8'h40, 1'b0);
    if (n == 0) begin
      expect_end("R7 probe stop", 0, 0);
      chk("R7 no byte", rd_valid, 0);
      return;
    end
    chk("R6 first ack", {cmd_valid, cmd_load, cmd_ack}, {2'b10, 1'(n != 1)});
    left = n;
    ab_seen = 1'b0;
    for (int i = 0; i < n - 1; i++) begin
      if (i == abort_before) begin
        abort = 1'b1; @(negedge clk); abort = 1'b0; ab_seen = 1'b1;
      end
      ctl_rdata = 8'(wbyte(a, i) ^ 8'h5A);
      ev(8'h50, 1'b0);
      left--;
      chk("R5 byte out", {rd_valid, rd_data}, {1'b1, 8'(wbyte(a, i) ^ 8'h5A)});
      chk(ab_seen ? "R11 abort nack" : "R6 ack bit", cmd_ack,
          (left != 1 && !ab_seen) ? 1 : 0);
    end
    ctl_rdata = 8'hC3;
    ev(8'h58, 1'b0);
    chk("R5 last byte", {rd_valid, rd_data}, {1'b1, 8'hC3});
    expect_end("R5 read stop", 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R3 watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 0; rd_mode = 0; ten_mode = 0; abort = 0;
    ctl_evt = 0; wr_valid = 1'b1; tgt_addr = '0; byte_cnt = '0;
    ctl_status = '0; ctl_rdata = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R3 reset outputs", {cmd_valid, done, rd_valid, wr_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: stray event while idle
    ev(8'h28, 1'b0);
    chk("R12 idle stop only", {cmd_valid, cmd_stop, cmd_reset, done}, 4'b1100);

    // R1/R8: every 7-bit address and direction, ended by a no-device code
    for (int a = 0; a < 128; a++) begin
      for (int d = 0; d < 2; d++) begin
        go(10'(a), 1'(d), 1'b0, 1);
        ev(8'h08, 1'b0);
        chk("R1 addr7", {cmd_load, cmd_data}, {1'b1, 8'(a * 2 + d)});
        ev(d ? 8'h48 : 8'h20, 1'b0);
        expect_end("R8 nodev", 1, 0);
      end
    end

    // R2: every ten-bit address and direction
    for (int a = 0; a < 1024; a++) begin
      for (int d = 0; d < 2; d++) begin
        go(10'(a), 1'(d), 1'b1, 2);
        ev(8'h10, 1'b0);
        chk("R2 first byte", {cmd_load, cmd_data}, {1'b1, 8'(240 + (a / 256) * 2 + d)});
        ev(d ? 8'h40 : 8'h18, 1'b0);
        chk("R2 second byte", {cmd_load, cmd_data, done}, {1'b1, 8'(a % 256), 1'b0});
        ev(8'h30, 1'b0);
        expect_end("R8 nodev 30", 1, 0);
      end
    end

    // R9/R13: status sweep after START of an empty write (0x50 excluded)
    for (int s = 0; s < 256; s++) begin
      if (s == 8'h50) continue;
      go(10'h2A, 1'b0, 1'b0, 0);
      ev(8'h08, 1'b0);
      ev(8'(s), 1'b0);
      if (s == 8'h08 || s == 8'h10) begin
        chk("R1 restart reloads", {cmd_load, cmd_data, done}, {1'b1, 8'h54, 1'b0});
        ev(8'h30, 1'b0);
        expect_end("R8 after restart", 1, 0);
      end else if (s == 8'h18 || s == 8'h28 || s == 8'hD0 || s == 8'h40 || s == 8'hE0) begin
        expect_end("R13 empty ok", 0, 0);
      end else if (s == 8'h58) begin
        chk("R5 58 byte", rd_valid, 1);
        expect_end("R5 58 end", 0, 0);
      end else if (s == 8'h20 || s == 8'h30 || s == 8'h48) begin
        expect_end("R8 sweep nodev", 1, 0);
      end else begin
        expect_end("R9 unexpected", 2, 1);
      end
    end

    // R4/R5/R6/R7: message lengths
    for (int n = 0; n < 5; n++) run_write(17 + n, n, -1);
    for (int n = 0; n < 5; n++) run_read(40 + n, n, -1);

    // R4: producer stall while waiting for a byte
    go(10'h11, 1'b0, 1'b0, 1);
    ev(8'h08, 1'b0);
    wr_valid = 1'b0;
    ev(8'h18, 1'b0);
    chk("R4 stall ready", {wr_ready, cmd_valid}, 2'b10);
    @(negedge clk);
    chk("R4 stall no cmd", {wr_ready, cmd_valid}, 2'b10);
    wr_data = 8'h9E; wr_valid = 1'b1;
    @(negedge clk);
    chk("R4 stall load", {cmd_load, cmd_data}, {1'b1, 8'h9E});
    ev(8'h28, 1'b0);
    expect_end("R4 stall end", 0, 0);

    // R10: abort with the same-cycle ack after one byte, and abort before any byte
    run_write(33, 3, 1);
    go(10'h21, 1'b0, 1'b0, 3);
    ev(8'h08, 1'b0);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    wr_data = 8'h66;
    ev(8'h18, 1'b0);
    chk("R10 first byte kept", wr_ready, 1);
    @(negedge clk);
    chk("R10 first load", {cmd_load, cmd_data}, {1'b1, 8'h66});
    ev(8'h28, 1'b0);
    expect_end("R10 abort later", 0, 0);

    // R11: abort during a read
    run_read(50, 4, 0);

    // R3: start ignored while busy
    go(10'h05, 1'b0, 1'b0, 0);
    start = 1'b1; tgt_addr = 10'h3FF; rd_mode = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R3 busy start ignored", cmd_valid, 0);
    ev(8'h08, 1'b0);
    chk("R3 params kept", cmd_data, 8'h0A);
    ev(8'h18, 1'b0);
    expect_end("R3 end", 0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule